// File: doc/BRIEF.md
# Fuse Shadow Read Controller

This block lets a processor bus read a bank of one-time-programmable fuse words without touching the fuse array on every access. Software requests the bank to open through a single control register. The block then waits a fixed wake-up time, streams every fuse word into a row of shadow registers at one word per clock, and drops its busy flag. From then on the shadow words are ordinary read-only registers at a fixed stride. The fuse array is modelled inside the block as a small synchronous ROM whose contents are computed from a seed. Fuse programming is not part of this block.

The control register has set, clear and toggle alias addresses beside its base address. A second open request that arrives while a copy is still running is refused and flagged. Reads of a shadow word during a copy return a fixed poison pattern, so software that skips the busy poll gets an obviously wrong value instead of stale data.

Top module: `fuse_shadow_ctrl`

## Requirements
- R1: After reset the control register reads 0 and every shadow word reads 0.
- R2: The control register answers at byte offsets 0x0 (plain write), 0x4 (OR the data in), 0x8 (AND-NOT the data in) and 0xC (XOR the data in), and all four offsets read the same value. Bit 0 is OPEN and bit 2 is ERROR, and both follow the alias rules. Bit 1 is BUSY, and writes have no effect on it. All other bits read 0.
- R3: An open request is a write to offset 0x0, 0x4 or 0xC with data bit 0 set that leaves OPEN at 1. An open request made while BUSY is 0 raises BUSY from the next cycle. BUSY then stays high for exactly WAKE_CYCLES + WORDS + 1 cycles, which is 41 with the defaults.
- R4: After BUSY falls, shadow word k reads at byte offset 0x100 + 0x10*k and holds fuse word k, which is 0x5EED0000 + k*0x1111 with the defaults (WORDS = 8).
- R5: A read of any shadow word while BUSY is 1 returns 0xBADABADA.
- R6: An open request made while BUSY is 1 sets ERROR and does not start a second copy, so the running copy ends at its original time.
- R7: Writing 0x4 to the clear alias (offset 0x8) returns ERROR to 0 and leaves OPEN unchanged.
- R8: Clearing OPEN after a copy leaves every shadow word at its copied value.
- R9: Reads at addresses outside the control register and the shadow words, including addresses inside the shadow range that are not on the stride, return 0. Writes to shadow addresses have no effect.
- R10: Clearing OPEN while BUSY is 1 does not shorten or abort the running copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (12) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Opening is tried through three routes: the set alias on a closed bank, the set alias on a bank that is already open, and an open with OPEN cleared partway through. All three must give the same 41-cycle busy window, which separates a real restart from a flag update. A second open request injected in mid-copy must keep that window length and raise ERROR, which shows the request was refused and not restarted. Reads taken during the copy, after a close, off the stride and past the last word separate the poison, retained, unmapped and ignored-write cases from one another.

// File: rtl/fuse_shadow_pkg.sv
package fuse_shadow_pkg;

   localparam int DATA_W  = 32;
   localparam int BIT_OPEN = 0;
   localparam int BIT_BUSY = 1;
   localparam int BIT_ERR  = 2;

   localparam logic [DATA_W-1:0] POISON = 32'hBADA_BADA;

   typedef enum logic [1:0] {
      ALIAS_WRITE = 2'd0,
      ALIAS_SET   = 2'd1,
      ALIAS_CLR   = 2'd2,
      ALIAS_TOG   = 2'd3
   } alias_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_WAKE,
      SEQ_COPY,
      SEQ_DRAIN
   } seq_state_e;

   function automatic logic apply_alias(input logic cur, input logic d, input alias_e op);
      logic r;
      case (op)
         ALIAS_WRITE: r = d;
         ALIAS_SET:   r = cur | d;
         ALIAS_CLR:   r = cur & ~d;
         default:     r = cur ^ d;
      endcase
      return r;
   endfunction

   function automatic logic [DATA_W-1:0] fuse_word(input logic [DATA_W-1:0] seed, input int idx);
      return seed + DATA_W'(idx) * 32'h0000_1111;
   endfunction

endpackage

// File: rtl/fuse_rom.sv
module fuse_rom
   import fuse_shadow_pkg::*;
#(
   parameter int                WORDS = 8,
   parameter logic [DATA_W-1:0] SEED  = 32'h5EED_0000,
   localparam int               IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_q
);

   logic [DATA_W-1:0] cells [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_cell
      assign cells[gi] = fuse_word(SEED, gi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= cells[rd_idx];
   end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
   import fuse_shadow_pkg::*;
#(
   parameter int  WORDS       = 8,
   parameter int  WAKE_CYCLES = 32,
   localparam int IDX_W       = $clog2(WORDS),
   localparam int CNT_W       = $clog2(WAKE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             rom_en,
   output logic [IDX_W-1:0] rom_idx,
   output logic             sh_we,
   output logic [IDX_W-1:0] sh_idx
);

   localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);
   localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(WORDS - 1);

   seq_state_e       state_q;
   logic [CNT_W-1:0] wake_q;
   logic [IDX_W-1:0] idx_q;

   assign busy    = (state_q != SEQ_IDLE);
   assign rom_en  = (state_q == SEQ_COPY);
   assign rom_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         wake_q  <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               wake_q <= '0;
               idx_q  <= '0;
               if (start) state_q <= SEQ_WAKE;
            end
            SEQ_WAKE: begin
               wake_q <= wake_q + 1'b1;
               if (wake_q == WAKE_LAST) state_q <= SEQ_COPY;
            end
            SEQ_COPY: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_LAST) state_q <= SEQ_DRAIN;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // shadow write trails the ROM fetch by one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_we  <= 1'b0;
         sh_idx <= '0;
      end else begin
         sh_we  <= rom_en;
         sh_idx <= idx_q;
      end
   end

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
   import fuse_shadow_pkg::*;
#(
   parameter int  WORDS = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rword
);

   logic [DATA_W-1:0] words_q [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          words_q[gi] <= '0;
         else if (we && widx == IDX_W'(gi))   words_q[gi] <= wdata;
      end
   end

   assign rword = words_q[ridx];

endmodule

// File: rtl/fuse_shadow_ctrl.sv
module fuse_shadow_ctrl
   import fuse_shadow_pkg::*;
#(
   parameter int                ADDR_W      = 12,
   parameter int                WORDS       = 8,
   parameter int                WAKE_CYCLES = 32,
   parameter int                SHADOW_BASE = 'h100,
   parameter int                STRIDE      = 'h10,
   parameter logic [DATA_W-1:0] FUSE_SEED   = 32'h5EED_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int IDX_W  = $clog2(WORDS);
   localparam int S_LOG  = $clog2(STRIDE);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SHADOW_BASE);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORDS * STRIDE);

   if (WORDS < 2) begin : g_bad_words
      $error("fuse_shadow_ctrl: WORDS must be at least 2");
   end
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("fuse_shadow_ctrl: WAKE_CYCLES must be at least 1");
   end
   if (STRIDE < 16 || (1 << S_LOG) != STRIDE) begin : g_bad_stride
      $error("fuse_shadow_ctrl: STRIDE must be a power of two, 16 or more");
   end
   if (SHADOW_BASE < 16 || SHADOW_BASE + WORDS * STRIDE > (1 << ADDR_W)) begin : g_bad_base
      $error("fuse_shadow_ctrl: shadow window must sit above the control register and fit in ADDR_W");
   end

   // control register state
   logic open_q, err_q;
   logic busy;

   // write decode
   logic   ctrl_hit;
   alias_e op;
   logic   open_nx, err_nx;
   logic   open_req, start, collide;

   assign ctrl_hit = (bus_addr[ADDR_W-1:4] == '0);
   assign op       = alias_e'(bus_addr[3:2]);
   assign open_nx  = apply_alias(open_q, bus_wdata[BIT_OPEN], op);
   assign err_nx   = apply_alias(err_q,  bus_wdata[BIT_ERR],  op);
   assign open_req = bus_wr && ctrl_hit && (op != ALIAS_CLR) && bus_wdata[BIT_OPEN] && open_nx;
   assign start    = open_req && !busy;
   assign collide  = open_req && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (bus_wr && ctrl_hit) open_q <= open_nx;
         if (collide)                err_q <= 1'b1;
         else if (bus_wr && ctrl_hit) err_q <= err_nx;
      end
   end

   // sequencer, fuse array and shadow storage
   logic             rom_en, sh_we;
   logic [IDX_W-1:0] rom_idx, sh_idx, rd_idx;
   logic [DATA_W-1:0] rom_q, sh_word;

   fuse_seq #(.WORDS(WORDS), .WAKE_CYCLES(WAKE_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .rom_en(rom_en), .rom_idx(rom_idx), .sh_we(sh_we), .sh_idx(sh_idx)
   );

   fuse_rom #(.WORDS(WORDS), .SEED(FUSE_SEED)) u_rom (
      .clk(clk), .rst_n(rst_n), .rd_en(rom_en), .rd_idx(rom_idx), .rd_q(rom_q)
   );

   fuse_shadow_bank #(.WORDS(WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(sh_we), .widx(sh_idx), .wdata(rom_q),
      .ridx(rd_idx), .rword(sh_word)
   );

   // read decode
   logic [ADDR_W-1:0] sh_off;
   logic              sh_hit, ctrl_rd;
   logic [DATA_W-1:0] ctrl_word;

   assign sh_off  = bus_addr - BASE_A;
   assign sh_hit  = (bus_addr >= BASE_A) && (sh_off < SPAN_A) && (sh_off[S_LOG-1:0] == '0);
   assign rd_idx  = sh_off[S_LOG +: IDX_W];
   assign ctrl_rd = ctrl_hit && (bus_addr[1:0] == 2'b00);

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_OPEN] = open_q;
      ctrl_word[BIT_BUSY] = busy;
      ctrl_word[BIT_ERR]  = err_q;
   end

   always_comb begin
      if (ctrl_rd)     bus_rdata = ctrl_word;
      else if (sh_hit) bus_rdata = busy ? POISON : sh_word;
      else             bus_rdata = '0;
   end

endmodule

// File: rtl/fuse_shadow_ctrl_chk.sv
module fuse_shadow_ctrl_chk
   import fuse_shadow_pkg::*;
#(
   parameter int BUSY_CYC = 41
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              start,
   input logic              collide,
   input logic              err_q,
   input logic              sh_we,
   input logic              sh_hit,
   input logic              ctrl_rd,
   input logic              bus_wr,
   input logic              ctrl_hit,
   input logic [3:0]        addr_lo,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata
);

   logic [15:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   // R3: busy starts only from an accepted request
   a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3: busy window has the fixed length
   a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == 16'(BUSY_CYC));

   // R3: window never overruns
   a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_cnt < 16'(BUSY_CYC));

   // R5: shadow reads during copy are poisoned
   a_r5_poison: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sh_hit && !ctrl_rd) |-> rdata == POISON);

   // R6: a refused request flags the error
   a_r6_collide_err: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> err_q);

   // R6: shadow writes happen only inside the busy window
   a_r6_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sh_we |-> busy);

   // R7: clear alias removes the error
   a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctrl_hit && addr_lo == 4'h8 && wdata[BIT_ERR] && !collide) |=> !err_q);

endmodule

bind fuse_shadow_ctrl fuse_shadow_ctrl_chk #(.BUSY_CYC(WAKE_CYCLES + WORDS + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .collide(collide),
   .err_q(err_q), .sh_we(sh_we), .sh_hit(sh_hit), .ctrl_rd(ctrl_rd),
   .bus_wr(bus_wr), .ctrl_hit(ctrl_hit), .addr_lo(bus_addr[3:0]),
   .wdata(bus_wdata), .rdata(bus_rdata)
);

// File: tb/fuse_shadow_ctrl_tb.sv
module fuse_shadow_ctrl_tb;

   localparam int BUSY_LEN = 41;
   localparam int NWORDS   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fuse_shadow_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] exp_word(int k);
      return 32'h5EED_0000 + 32'(k) * 32'h0000_1111;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = '0;
   endtask

   // counts busy cycles right after a start; optional write at a given cycle
   task automatic count_busy(int inj_at, logic [11:0] inj_a, logic [31:0] inj_d, output int n);
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         bus_addr = '0;
         #0;
         if (bus_rdata[1] !== 1'b1) break;
         n++;
         if (n == inj_at) begin
            bus_wr = 1'b1; bus_addr = inj_a; bus_wdata = inj_d;
            @(posedge clk); #1;
            bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
         end
      end
   endtask

   task automatic check_shadows(string req);
      logic [31:0] d;
      for (int k = 0; k < NWORDS; k++) begin
         rd(12'h100 + 12'(k * 16), d);
         check(req, d, exp_word(k));
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(12'h000, d); check("R1 ctrl", d, 32'h0);
      rd(12'h100, d); check("R1 shadow0", d, 32'h0);
      rd(12'h170, d); check("R1 shadow7", d, 32'h0);
   endtask

   task automatic t_alias;
      logic [31:0] d;
      wr(12'h004, 32'h4); rd(12'h000, d); check("R2 set err", d, 32'h4);
      rd(12'h00C, d);                     check("R2 alias read", d, 32'h4);
      wr(12'h00C, 32'h4); rd(12'h000, d); check("R2 toggle err", d, 32'h0);
      wr(12'h000, 32'hFFFF_FFF6); rd(12'h000, d); check("R2 busy ro", d, 32'h4);
      wr(12'h008, 32'h4); rd(12'h000, d); check("R2 clr err", d, 32'h0);
   endtask

   task automatic t_copy;
      int n;
      logic [31:0] d;
      wr(12'h004, 32'h1);
      count_busy(0, '0, '0, n);
      check("R3 busy length", 32'(n), 32'(BUSY_LEN));
      rd(12'h000, d); check("R3 ctrl after", d, 32'h1);
      check_shadows("R4 shadow");
   endtask

   task automatic t_poison_collide;
      int n;
      logic [31:0] d;
      wr(12'h004, 32'h1);
      rd(12'h110, d); check("R5 poison", d, 32'hBADA_BADA);
      rd(12'h000, d); check("R5 busy seen", d, 32'h3);
      // two cycles consumed by reads; inject a second open request later
      count_busy(5, 12'h004, 32'h1, n);
      check("R6 no restart", 32'(n + 2), 32'(BUSY_LEN));
      rd(12'h000, d); check("R6 error set", d, 32'h5);
      wr(12'h008, 32'h4);
      rd(12'h000, d); check("R7 err cleared", d, 32'h1);
   endtask

   task automatic t_close;
      logic [31:0] d;
      wr(12'h008, 32'h1);
      rd(12'h000, d); check("R8 closed", d, 32'h0);
      check_shadows("R8 kept");
   endtask

   task automatic t_close_busy;
      int n;
      logic [31:0] d;
      wr(12'h00C, 32'h1);
      count_busy(3, 12'h008, 32'h1, n);
      check("R10 full length", 32'(n), 32'(BUSY_LEN));
      rd(12'h000, d); check("R10 ctrl", d, 32'h0);
      check_shadows("R10 shadow");
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      rd(12'h050, d); check("R9 gap", d, 32'h0);
      rd(12'h104, d); check("R9 off stride", d, 32'h0);
      rd(12'h180, d); check("R9 past end", d, 32'h0);
      rd(12'h002, d); check("R9 ctrl misaligned", d, 32'h0);
      wr(12'h110, 32'h0);
      rd(12'h110, d); check("R9 shadow write ignored", d, exp_word(1));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_alias();
      t_copy();
      t_poison_collide();
      t_close();
      t_close_busy();
      t_unmapped();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule